// File: doc/BRIEF.md
# Nibble-Serial SIMD Processing Element

One processing element of a lockstep SIMD array. A central controller broadcasts a 4-bit opcode and three register selects to every element at once and pulses `issue`. The element runs 32-bit add, subtract and bitwise operations on registers only, using an arithmetic slice only 4 bits wide. Each operation therefore takes eight clocks, one nibble per clock starting at the least significant nibble. A running carry links each nibble to the next. A separate 1-bit logic unit maintains an `active` mask bit. When the mask is clear, the element still steps through every instruction in lockstep, but its register file and arithmetic flags stay unchanged.

Data enters through a broadcast word that a load opcode writes into a register. Any register can be read out combinationally through a peek port. The controller is a three-state machine. **IDLE** waits. On `issue` it takes the *launch* transition to **RUN**, which processes nibbles 0 to 6 and takes the *final-slice* transition to **LAST** after nibble 6. **LAST** processes nibble 7, raises `done`, performs write-back and flag capture, and takes the *retire* transition back to **IDLE**.

Top module: `nibble_pe`

## Requirements
- R1: After reset, `busy`, `done`, `carry_flag`, `ovf_flag` and `zero_flag` are 0, `active` is 1, and every register reads 0.
- R2: Opcode 0 (ADD) writes `(A+B) mod 2^32` to the destination. `carry_flag` takes bit 32 of the unsigned sum. `ovf_flag` is set when A and B have equal sign bits and the result sign differs from them.
- R3: Opcode 1 (SUB) writes `(A-B) mod 2^32`. `carry_flag` is 1 when A >= B unsigned (no borrow). `ovf_flag` is set when the sign bits of A and B differ and the result sign differs from A's.
- R4: Opcodes 2 (AND), 3 (OR) and 4 (XOR) write the bitwise result and clear both `carry_flag` and `ovf_flag`.
- R5: After any of opcodes 0 to 4 executes on an active element, `zero_flag` is 1 exactly when the written 32-bit result is 0.
- R6: Opcode 5 (LDI) writes `bcast_word`, as it stood at launch, to the destination and leaves all three arithmetic flags unchanged.
- R7: An `issue` accepted in IDLE makes `busy` high from the next cycle. `done` is high for exactly one cycle, the eighth cycle after the launch edge. `busy` falls one cycle after `done`, and the results are visible from then on.
- R8: `issue` while `busy` is high is ignored. It changes neither the timing of the running operation nor any register.
- R9: Mask opcodes execute regardless of `active` and leave the registers and arithmetic flags alone. Opcode 8 sets `active` to 1. Opcode 9 sets it to `carry_flag`. Opcode 10 sets it to the inverse of `carry_flag`. Opcode 11 sets it to `zero_flag`. Opcode 12 sets it to `active AND carry_flag`.
- R10: While `active` is 0, opcodes 0 to 5 write no register and change no flag, but `done` and `busy` follow the R7 timing.
- R11: Source operands are captured at launch, so the destination may equal either source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common array clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue | input | 1 | Start strobe for the broadcast instruction |
| opcode | input | 4 | Broadcast operation code |
| dst_sel | input | 4 | Destination register select |
| src_a_sel | input | 4 | First source register select |
| src_b_sel | input | 4 | Second source register select |
| bcast_word | input | 32 | Broadcast data for the load opcode |
| peek_sel | input | 4 | Register select for the read-out port |
| peek_word | output | 32 | Contents of the register chosen by `peek_sel` |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle pulse on the final nibble cycle |
| carry_flag | output | 1 | Carry (no-borrow) from the last arithmetic operation |
| ovf_flag | output | 1 | Signed overflow from the last arithmetic operation |
| zero_flag | output | 1 | Result-was-zero from the last arithmetic or logic operation |
| active | output | 1 | Element mask bit |

## Verification
A carry lost or duplicated between nibbles shows up as a wrong destination value and a wrong `carry_flag` at the first `busy` fall after the operation. The operand sweep pairs values whose carry must ripple through all eight nibbles, such as all-ones plus one. A nibble counter or state machine that miscounts moves the `done` pulse off the eighth cycle, widens it, or leaves `busy` stuck, and this is visible within ten cycles of the launch. A mask bit in the wrong state shows either as a register that changed while disabled or as an `active` level that differs from the value predicted from the flags. Both can be read at the ports immediately after `busy` falls.

// File: rtl/pe_pkg.sv
package pe_pkg;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_SUB   = 4'd1,
        OP_AND   = 4'd2,
        OP_OR    = 4'd3,
        OP_XOR   = 4'd4,
        OP_LDI   = 4'd5,
        OP_MSET  = 4'd8,
        OP_MCY   = 4'd9,
        OP_MNCY  = 4'd10,
        OP_MZERO = 4'd11,
        OP_MANDC = 4'd12
    } pe_op_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_RUN  = 2'd1,
        S_LAST = 2'd2
    } pe_state_e;

    function automatic logic op_is_arith(input pe_op_e op);
        return (op == OP_ADD) || (op == OP_SUB);
    endfunction

    function automatic logic op_is_logic(input pe_op_e op);
        return (op == OP_AND) || (op == OP_OR) || (op == OP_XOR);
    endfunction

    function automatic logic op_writes_reg(input pe_op_e op);
        return op_is_arith(op) || op_is_logic(op) || (op == OP_LDI);
    endfunction

endpackage

// File: rtl/pe_regfile.sv
module pe_regfile #(
    parameter int DATA_W = 32,
    parameter int NREGS  = 16,
    localparam int RA_W  = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [RA_W-1:0]   rd_a_addr,
    input  logic [RA_W-1:0]   rd_b_addr,
    input  logic [RA_W-1:0]   rd_p_addr,
    output logic [DATA_W-1:0] rd_a_data,
    output logic [DATA_W-1:0] rd_b_data,
    output logic [DATA_W-1:0] rd_p_data
);

    logic [DATA_W-1:0] regs [NREGS];

    generate
        for (genvar r = 0; r < NREGS; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    regs[r] <= '0;
                end else if (wr_en && (wr_addr == RA_W'(r))) begin
                    regs[r] <= wr_data;
                end
            end
        end
    endgenerate

    assign rd_a_data = regs[rd_a_addr];
    assign rd_b_data = regs[rd_b_addr];
    assign rd_p_data = regs[rd_p_addr];

endmodule

// File: rtl/pe_slice_alu.sv
module pe_slice_alu
    import pe_pkg::*;
#(
    parameter int NIB_W = 4
) (
    input  pe_op_e           op,
    input  logic [NIB_W-1:0] a,
    input  logic [NIB_W-1:0] b,
    input  logic             cin,
    output logic [NIB_W-1:0] y,
    output logic             cout,
    output logic             ovf
);

    logic [NIB_W-1:0] b_eff;
    logic [NIB_W-1:0] sum;
    logic [NIB_W:0]   c;

    assign b_eff = (op == OP_SUB) ? ~b : b;
    assign c[0]  = cin;

    generate
        for (genvar i = 0; i < NIB_W; i++) begin : g_bit
            assign sum[i]   = a[i] ^ b_eff[i] ^ c[i];
            assign c[i+1]   = (a[i] & b_eff[i]) | (c[i] & (a[i] ^ b_eff[i]));
        end
    endgenerate

    always_comb begin
        y    = '0;
        cout = 1'b0;
        ovf  = 1'b0;
        case (op)
            OP_ADD, OP_SUB: begin
                y    = sum;
                cout = c[NIB_W];
                ovf  = c[NIB_W] ^ c[NIB_W-1];
            end
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_LDI:  y = b;
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/pe_mask_unit.sv
module pe_mask_unit
    import pe_pkg::*;
(
    input  pe_op_e op,
    input  logic   active_q,
    input  logic   carry_q,
    input  logic   zero_q,
    output logic   is_mask,
    output logic   active_nx
);

    always_comb begin
        is_mask   = 1'b1;
        active_nx = active_q;
        case (op)
            OP_MSET:  active_nx = 1'b1;
            OP_MCY:   active_nx = carry_q;
            OP_MNCY:  active_nx = ~carry_q;
            OP_MZERO: active_nx = zero_q;
            OP_MANDC: active_nx = active_q & carry_q;
            default:  is_mask   = 1'b0;
        endcase
    end

endmodule

// File: rtl/nibble_pe.sv
module nibble_pe
    import pe_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int NIB_W  = 4,
    parameter int NREGS  = 16,
    localparam int RA_W  = $clog2(NREGS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [3:0]        opcode,
    input  logic [RA_W-1:0]   dst_sel,
    input  logic [RA_W-1:0]   src_a_sel,
    input  logic [RA_W-1:0]   src_b_sel,
    input  logic [DATA_W-1:0] bcast_word,
    input  logic [RA_W-1:0]   peek_sel,
    output logic [DATA_W-1:0] peek_word,
    output logic              busy,
    output logic              done,
    output logic              carry_flag,
    output logic              ovf_flag,
    output logic              zero_flag,
    output logic              active
);

    localparam int NIBS  = DATA_W / NIB_W;
    localparam int CNT_W = $clog2(NIBS);
    localparam logic [CNT_W-1:0] PENULT = CNT_W'(NIBS - 2);

    pe_state_e         state_q, state_nx;
    pe_op_e            op_q;
    logic [RA_W-1:0]   dst_q;
    logic [DATA_W-1:0] a_sh, b_sh, r_sh;
    logic              carry_run;
    logic [CNT_W-1:0]  slice_cnt;

    logic [DATA_W-1:0] rd_a, rd_b, result;
    logic [NIB_W-1:0]  slice_y;
    logic              slice_cout, slice_ovf;
    logic              launch, wr_en, flag_upd;
    logic              is_mask, active_nx;

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_nx;
    end

    // ---------------- transitions: launch / final-slice / retire ----------------
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            S_IDLE:  if (issue) state_nx = S_RUN;
            S_RUN:   if (slice_cnt == PENULT) state_nx = S_LAST;
            S_LAST:  state_nx = S_IDLE;
            default: state_nx = S_IDLE;
        endcase
    end

    // ---------------- outputs of the machine ----------------
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            S_IDLE:  ;
            S_RUN:   busy = 1'b1;
            S_LAST:  begin busy = 1'b1; done = 1'b1; end
            default: ;
        endcase
    end

    assign launch   = (state_q == S_IDLE) && issue;
    assign result   = {slice_y, r_sh[DATA_W-1:NIB_W]};
    assign wr_en    = (state_q == S_LAST) && active && op_writes_reg(op_q);
    assign flag_upd = (state_q == S_LAST) && active
                      && (op_is_arith(op_q) || op_is_logic(op_q));

    // ---------------- nibble-serial datapath ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_q       <= OP_ADD;
            dst_q      <= '0;
            a_sh       <= '0;
            b_sh       <= '0;
            r_sh       <= '0;
            carry_run  <= 1'b0;
            slice_cnt  <= '0;
            carry_flag <= 1'b0;
            ovf_flag   <= 1'b0;
            zero_flag  <= 1'b0;
            active     <= 1'b1;
        end else if (launch) begin
            op_q      <= pe_op_e'(opcode);
            dst_q     <= dst_sel;
            a_sh      <= rd_a;
            b_sh      <= (pe_op_e'(opcode) == OP_LDI) ? bcast_word : rd_b;
            carry_run <= (pe_op_e'(opcode) == OP_SUB);
            slice_cnt <= '0;
        end else if (state_q != S_IDLE) begin
            a_sh      <= a_sh >> NIB_W;
            b_sh      <= b_sh >> NIB_W;
            r_sh      <= result;
            carry_run <= slice_cout;
            slice_cnt <= slice_cnt + 1'b1;
            if (flag_upd) begin
                carry_flag <= op_is_arith(op_q) ? slice_cout : 1'b0;
                ovf_flag   <= op_is_arith(op_q) ? slice_ovf  : 1'b0;
                zero_flag  <= (result == '0);
            end
            if ((state_q == S_LAST) && is_mask) begin
                active <= active_nx;
            end
        end
    end

    pe_slice_alu #(.NIB_W(NIB_W)) u_alu (
        .op   (op_q),
        .a    (a_sh[NIB_W-1:0]),
        .b    (b_sh[NIB_W-1:0]),
        .cin  (carry_run),
        .y    (slice_y),
        .cout (slice_cout),
        .ovf  (slice_ovf)
    );

    pe_mask_unit u_mask (
        .op        (op_q),
        .active_q  (active),
        .carry_q   (carry_flag),
        .zero_q    (zero_flag),
        .is_mask   (is_mask),
        .active_nx (active_nx)
    );

    pe_regfile #(.DATA_W(DATA_W), .NREGS(NREGS)) u_rf (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (dst_q),
        .wr_data   (result),
        .rd_a_addr (src_a_sel),
        .rd_b_addr (src_b_sel),
        .rd_p_addr (peek_sel),
        .rd_a_data (rd_a),
        .rd_b_data (rd_b),
        .rd_p_data (peek_word)
    );

endmodule

// File: rtl/pe_checker.sv
module pe_checker #(
    parameter int NIBS = 8
) (
    input logic clk,
    input logic rst_n,
    input logic issue,
    input logic busy,
    input logic done,
    input logic active,
    input logic carry_flag,
    input logic ovf_flag,
    input logic zero_flag
);

    localparam int CW = $clog2(NIBS) + 1;
    logic [CW-1:0] cyc;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)               cyc <= '0;
        else if (issue && !busy)  cyc <= '0;
        else if (busy)            cyc <= cyc + 1'b1;
    end

    assert_launch_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (issue && !busy) |=> busy);

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_latency_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (int'(cyc) == NIBS - 1));

    assert_retire_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy);

    assert_busy_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> busy);

    assert_masked_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !active) |=> ($stable(carry_flag) && $stable(ovf_flag) && $stable(zero_flag)));

endmodule

bind nibble_pe pe_checker #(.NIBS(NIBS)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue      (issue),
    .busy       (busy),
    .done       (done),
    .active     (active),
    .carry_flag (carry_flag),
    .ovf_flag   (ovf_flag),
    .zero_flag  (zero_flag)
);

// File: tb/sim_nibble_pe.sv
`timescale 1ns/1ps
module sim_nibble_pe;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [3:0]  opcode = '0;
    logic [3:0]  dst_sel = '0, src_a_sel = '0, src_b_sel = '0, peek_sel = '0;
    logic [31:0] bcast_word = '0;
    logic [31:0] peek_word;
    logic        busy, done, carry_flag, ovf_flag, zero_flag, active;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    nibble_pe u0 (
        .clk(clk), .rst_n(rst_n), .issue(issue), .opcode(opcode),
        .dst_sel(dst_sel), .src_a_sel(src_a_sel), .src_b_sel(src_b_sel),
        .bcast_word(bcast_word), .peek_sel(peek_sel), .peek_word(peek_word),
        .busy(busy), .done(done), .carry_flag(carry_flag), .ovf_flag(ovf_flag),
        .zero_flag(zero_flag), .active(active)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic peek(input int r, output logic [31:0] v);
        peek_sel = 4'(r);
        #1;
        v = peek_word;
    endtask

    function automatic logic [31:0] flags();
        return {29'd0, carry_flag, ovf_flag, zero_flag};
    endfunction

    // Issues one instruction and checks R7 timing; optional stray issue mid-run (R8).
    task automatic run_op(input logic [3:0] op, input int d, input int a, input int b,
                          input logic [31:0] w, input bit inject);
        int pos;
        int cnt;
        pos = 0;
        cnt = 0;
        @(negedge clk);
        opcode = op; dst_sel = 4'(d); src_a_sel = 4'(a); src_b_sel = 4'(b);
        bcast_word = w; issue = 1'b1;
        for (int i = 1; i <= 10; i++) begin
            @(negedge clk);
            if (done) begin cnt++; pos = i; end
            if (i == 1) check("R7 busy after launch", {31'd0, busy}, 32'd1);
            if (inject && i == 3) begin
                issue = 1'b1; opcode = 4'd5; dst_sel = 4'd15; bcast_word = 32'hDEAD_BEEF;
            end else begin
                issue = 1'b0;
            end
        end
        check("R7 done position/count/busy", {pos[15:0], cnt[7:0], 7'd0, busy},
              {16'd8, 8'd1, 8'd0});
    endtask

    function automatic logic [32:0] exp_add(input logic [31:0] a, input logic [31:0] b);
        return {1'b0, a} + {1'b0, b};
    endfunction

    function automatic logic [32:0] exp_sub(input logic [31:0] a, input logic [31:0] b);
        return {1'b0, a} + {1'b0, ~b} + 33'd1;
    endfunction

    task automatic test_pair(input logic [31:0] a, input logic [31:0] b);
        logic [31:0] v, fl;
        logic [32:0] s;
        logic        ov;
        fl = flags();
        run_op(4'd5, 1, 0, 0, a, 0);
        run_op(4'd5, 2, 0, 0, b, 0);
        check("R6 load keeps flags", flags(), fl);
        peek(1, v); check("R6 load value", v, a);
        // R2 ADD
        run_op(4'd0, 3, 1, 2, 32'd0, 0);
        s = exp_add(a, b);
        ov = (a[31] == b[31]) && (s[31] != a[31]);
        peek(3, v); check("R2 add result", v, s[31:0]);
        check("R2 R5 add flags", flags(), {29'd0, s[32], ov, s[31:0] == 32'd0});
        // R3 SUB
        run_op(4'd1, 3, 1, 2, 32'd0, 0);
        s = exp_sub(a, b);
        ov = (a[31] != b[31]) && (s[31] != a[31]);
        peek(3, v); check("R3 sub result", v, s[31:0]);
        check("R3 R5 sub flags", flags(), {29'd0, (a >= b), ov, s[31:0] == 32'd0});
        // R4 bitwise
        run_op(4'd2, 3, 1, 2, 32'd0, 0);
        peek(3, v); check("R4 and", v, a & b);
        check("R4 R5 and flags", flags(), {29'd0, 1'b0, 1'b0, (a & b) == 32'd0});
        run_op(4'd3, 3, 1, 2, 32'd0, 0);
        peek(3, v); check("R4 or", v, a | b);
        run_op(4'd4, 3, 1, 2, 32'd0, 0);
        peek(3, v); check("R4 xor", v, a ^ b);
        check("R4 R5 xor flags", flags(), {29'd0, 1'b0, 1'b0, (a ^ b) == 32'd0});
    endtask

    logic [31:0] corner [8] = '{32'h0000_0000, 32'h0000_0001, 32'h7FFF_FFFF, 32'h8000_0000,
                                32'hFFFF_FFFF, 32'h0000_000F, 32'hF0F0_F0F0, 32'h1234_5678};

    initial begin
        #750000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v, lcg_a, lcg_b;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 status after reset", {26'd0, busy, done, carry_flag, ovf_flag, zero_flag, active},
              32'd1);
        for (int r = 0; r < 16; r++) begin
            peek(r, v); check("R1 register zero", v, 32'd0);
        end

        // R2 R3 R4 R5 R6 sweep over corner operand pairs
        for (int i = 0; i < 8; i++)
            for (int j = 0; j < 8; j++)
                test_pair(corner[i], corner[j]);

        lcg_a = 32'h1357_9BDF;
        lcg_b = 32'h2468_ACE0;
        for (int k = 0; k < 40; k++) begin
            lcg_a = lcg_a * 32'd1664525 + 32'd1013904223;
            lcg_b = lcg_b * 32'd22695477 + 32'd1;
            test_pair(lcg_a, lcg_b);
        end

        // R11 destination equals source
        run_op(4'd5, 4, 0, 0, 32'h0F0F_0F0F, 0);
        run_op(4'd0, 4, 4, 4, 32'd0, 0);
        peek(4, v); check("R11 r4 = r4 + r4", v, 32'h1E1E_1E1E);

        // R8 stray issue while busy
        run_op(4'd5, 15, 0, 0, 32'h0000_0005, 0);
        run_op(4'd5, 6, 0, 0, 32'h0000_0010, 0);
        run_op(4'd0, 7, 6, 6, 32'd0, 1);
        peek(15, v); check("R8 stray load ignored", v, 32'h0000_0005);
        peek(7, v); check("R8 running op intact", v, 32'h0000_0020);

        // R9 R10 mask behaviour
        run_op(4'd5, 1, 0, 0, 32'd1, 0);
        run_op(4'd5, 2, 0, 0, 32'd2, 0);
        run_op(4'd5, 5, 0, 0, 32'h11, 0);
        run_op(4'd5, 8, 0, 0, 32'hFFFF_FFFF, 0);
        run_op(4'd1, 3, 1, 2, 32'd0, 0);                 // 1-2: carry 0, zero 0
        check("R3 borrow flags", flags(), 32'd0);
        run_op(4'd9, 0, 0, 0, 32'd0, 0);
        check("R9 mask from carry", {31'd0, active}, 32'd0);
        run_op(4'd5, 5, 0, 0, 32'h77, 0);
        peek(5, v); check("R10 masked load", v, 32'h11);
        run_op(4'd0, 5, 8, 1, 32'd0, 0);                 // would give 0 with carry
        peek(5, v); check("R10 masked add", v, 32'h11);
        check("R10 masked flags", flags(), 32'd0);
        run_op(4'd10, 0, 0, 0, 32'd0, 0);
        check("R9 mask from not-carry while disabled", {31'd0, active}, 32'd1);
        run_op(4'd11, 0, 0, 0, 32'd0, 0);
        check("R9 mask from zero", {31'd0, active}, 32'd0);
        run_op(4'd8, 0, 0, 0, 32'd0, 0);
        check("R9 mask set", {31'd0, active}, 32'd1);
        run_op(4'd12, 0, 0, 0, 32'd0, 0);
        check("R9 mask and carry", {31'd0, active}, 32'd0);
        run_op(4'd8, 0, 0, 0, 32'd0, 0);
        check("R9 flags untouched by mask ops", flags(), 32'd0);
        run_op(4'd0, 5, 8, 1, 32'd0, 0);
        peek(5, v); check("R2 add after re-enable", v, 32'd0);
        check("R2 R5 carry-out flags", flags(), 32'd5);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule